// File: doc/BRIEF.md
# Cascaded Fixed-Point Beam-Position Predictor

This block runs forward inference through four small fully connected networks in a chain. Each network has one hidden layer and predicts the x/y position at the next beam monitor along a transport line. A sequencer steps through the four stages in a fixed order. Stage 1 starts from a measured monitor position and four magnet currents. Each later stage takes the x/y pair predicted by the stage before it and adds fresh magnet currents read from the input stream.

Inputs arrive one Q8.8 value per beat on a valid/ready stream. Every stage result leaves on an output stream as one beat that carries the x/y pair and a stage tag, so the intermediate predictions can be observed as well as the final one. All coefficients are constants generated in logic from a fixed formula. A single multiply-accumulate unit evaluates one neuron term per cycle.

Top module: `cmlp_engine`

## Requirements
- R1: After reset, `s_tready_o` and `m_tvalid_o` are both low until a first input beat is offered.
- R2: The stages consume external beats in a fixed order. Stage 1 takes 6 beats: monitor x, monitor y, then four magnet currents. Stages 2, 3 and 4 take 1, 2 and 1 beats. A stage accepts no input until the previous stage's result beat has been accepted, and it asserts `s_tready_o` in the cycle after that acceptance.
- R3: The four stages have 6, 3, 4 and 3 inputs and 8, 8, 12 and 6 hidden neurons, with two outputs each. The inputs of stages 2 to 4 are ordered previous x, previous y, then the external values.
- R4: The coefficient for stage s (0..3), layer l (0 hidden, 1 output), neuron r and input c is computed from h = 97s + 53l + 31r + 17c + 7. It is 0 when h mod 4 = 0. Otherwise it is ((37h) mod 256) - 128 in Q8.8. The bias of a neuron uses c equal to that layer's input count.
- R5: Each neuron sums its full-width products with its bias scaled by 256. The sum is rounded by adding 128 and shifting arithmetically right by 8, then saturated to [-32768, 32767].
- R6: Hidden neurons apply a leaky rectifier to the rounded value: non-negative values pass unchanged and negative values are shifted arithmetically right by 7. Output neurons are linear.
- R7: An output beat carries x in bits [15:0], y in [31:16] and the stage number minus one in [33:32]. `m_tlast_o` is high only on the stage 4 beat.
- R8: While `m_tvalid_o` is high and `m_tready_i` is low, the output beat stays valid and unchanged.
- R9: After the stage 4 beat is accepted, the engine returns to idle and runs a complete new sequence from the next input beat.
- R10: `s_tready_o` is never high while an output beat is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| s_tdata_i | input | 16 | Input value, Q8.8 signed |
| s_tvalid_i | input | 1 | Input beat valid |
| s_tready_o | output | 1 | Engine accepts an input beat |
| m_tdata_o | output | 34 | Stage tag, y and x |
| m_tvalid_o | output | 1 | Output beat valid |
| m_tready_i | input | 1 | Downstream accepts the beat |
| m_tlast_o | output | 1 | Marks the final stage beat |

## Verification
The bench builds the engine with its default hidden sizes of 8, 8, 12 and 6, and a leaky shift of 7. These settings give the widest hidden layer (12) and the longest bias column index. They also give a negative slope small enough that hidden outputs rounding to -1 or 0 show up in the data. Full-scale positive and negative input vectors drive the output neurons into both saturation limits. Stalled and back-to-back sequences cover the hand-off between stages and the return to idle.

// File: rtl/cmlp_pkg.sv
package cmlp_pkg;
  localparam int DATA_W = 16;
  localparam int FRAC_W = 8;
  localparam int ACC_W  = 32;
  localparam int TAG_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STAGE1, ST_STAGE2, ST_STAGE3, ST_STAGE4, ST_DONE
  } stage_e;

  typedef enum logic [1:0] {PH_LOAD, PH_HID, PH_OUT, PH_EMIT} phase_e;

  // external beats per stage and first slot they land in
  function automatic int ext_count(logic [1:0] s);
    case (s)
      2'd0:    return 6;
      2'd2:    return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int ext_base(logic [1:0] s);
    return (s == 2'd0) ? 0 : 2;
  endfunction

  function automatic int in_count(logic [1:0] s);
    return (s == 2'd0) ? 6 : 2 + ext_count(s);
  endfunction

  function automatic logic signed [DATA_W-1:0] coef_val(int st, int ly, int r, int c);
    int h;
    logic [7:0] v;
    h = st*97 + ly*53 + r*31 + c*17 + 7;
    v = 8'(h*37);
    if ((h % 4) == 0) return '0;
    return DATA_W'(int'(v) - 128);
  endfunction

  function automatic logic signed [DATA_W-1:0] rnd_sat(logic signed [ACC_W-1:0] s);
    logic signed [ACC_W:0] t;
    t = ((ACC_W+1)'(s) + (ACC_W+1)'(1 << (FRAC_W-1))) >>> FRAC_W;
    if (t > (ACC_W+1)'(32767))  return 16'sh7fff;
    if (t < -(ACC_W+1)'(32768)) return 16'sh8000;
    return t[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/cmlp_coef.sv
module cmlp_coef
  import cmlp_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [1:0]               stage_i,
  input  logic                     layer_i,
  input  logic [CNT_W-1:0]         row_i,
  input  logic [CNT_W-1:0]         col_i,
  output logic signed [DATA_W-1:0] coef_o
);
  always_comb coef_o = coef_val(int'(stage_i), int'(layer_i), int'(row_i), int'(col_i));
endmodule

// File: rtl/cmlp_act.sv
module cmlp_act
  import cmlp_pkg::*;
#(
  parameter int NEG_SHIFT = 7
) (
  input  logic signed [DATA_W-1:0] x_i,
  output logic signed [DATA_W-1:0] y_o
);
  generate
    if (NEG_SHIFT == 0) begin : g_relu
      always_comb y_o = x_i[DATA_W-1] ? '0 : x_i;
    end else begin : g_leaky
      always_comb y_o = x_i[DATA_W-1] ? (x_i >>> NEG_SHIFT) : x_i;
    end
  endgenerate

  always_comb begin
    if (!x_i[DATA_W-1])
      AST_ACT_PASS: assert (y_o == x_i); // R6
    else
      AST_ACT_NEG: assert (y_o <= 0 && y_o >= x_i); // R6
  end
endmodule

// File: rtl/cmlp_mac.sv
module cmlp_mac
  import cmlp_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     step_i,
  input  logic                     fin_i,
  input  logic signed [DATA_W-1:0] coef_i,
  input  logic signed [DATA_W-1:0] opnd_i,
  output logic signed [DATA_W-1:0] res_o
);
  logic signed [ACC_W-1:0] acc_q, term, sum;

  // bias cycle adds coef aligned to product scale
  always_comb begin
    term  = fin_i ? (ACC_W'(coef_i) <<< FRAC_W) : ACC_W'(coef_i) * ACC_W'(opnd_i);
    sum   = acc_q + term;
    res_o = rnd_sat(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (step_i) acc_q <= fin_i ? '0 : sum;
  end
endmodule

// File: rtl/cmlp_engine.sv
module cmlp_engine
  import cmlp_pkg::*;
#(
  parameter int HID1_N    = 8,
  parameter int HID2_N    = 8,
  parameter int HID3_N    = 12,
  parameter int HID4_N    = 6,
  parameter int NEG_SHIFT = 7
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [DATA_W-1:0]          s_tdata_i,
  input  logic                       s_tvalid_i,
  output logic                       s_tready_o,
  output logic [TAG_W+2*DATA_W-1:0]  m_tdata_o,
  output logic                       m_tvalid_o,
  input  logic                       m_tready_i,
  output logic                       m_tlast_o
);
  localparam int MAX_HID = (HID1_N > HID2_N ? HID1_N : HID2_N) > (HID3_N > HID4_N ? HID3_N : HID4_N)
                         ? (HID1_N > HID2_N ? HID1_N : HID2_N) : (HID3_N > HID4_N ? HID3_N : HID4_N);
  localparam int MAX_DIM = MAX_HID > 6 ? MAX_HID : 6;
  localparam int VEC_N   = MAX_DIM + 1;
  localparam int CNT_W   = $clog2(VEC_N);

  function automatic int hid_count(logic [1:0] s);
    case (s)
      2'd0:    return HID1_N;
      2'd1:    return HID2_N;
      2'd2:    return HID3_N;
      default: return HID4_N;
    endcase
  endfunction

  stage_e state_q;
  phase_e phase_q;
  logic [CNT_W-1:0] ld_q, row_q, col_q;
  logic signed [DATA_W-1:0] in_vec_q  [VEC_N];
  logic signed [DATA_W-1:0] hid_vec_q [VEC_N];
  logic signed [DATA_W-1:0] out_x_q, out_y_q;

  logic [1:0]               si;
  logic                     active, layer, fin, step, s_hs, m_hs;
  logic [CNT_W-1:0]         cur_in, cur_rows, ld_last;
  logic signed [DATA_W-1:0] coef, opnd, mac_res, act_res;

  always_comb begin
    case (state_q)
      ST_STAGE2: si = 2'd1;
      ST_STAGE3: si = 2'd2;
      ST_STAGE4: si = 2'd3;
      default:   si = 2'd0;
    endcase
    active   = (state_q inside {ST_STAGE1, ST_STAGE2, ST_STAGE3, ST_STAGE4});
    layer    = (phase_q == PH_OUT);
    cur_in   = layer ? CNT_W'(hid_count(si)) : CNT_W'(in_count(si));
    cur_rows = layer ? CNT_W'(2) : CNT_W'(hid_count(si));
    ld_last  = CNT_W'(ext_base(si) + ext_count(si) - 1);
    fin      = (col_q == cur_in);
    step     = active && (phase_q inside {PH_HID, PH_OUT});
    opnd     = layer ? hid_vec_q[col_q] : in_vec_q[col_q];
    s_tready_o = active && (phase_q == PH_LOAD);
    m_tvalid_o = active && (phase_q == PH_EMIT);
    m_tlast_o  = (state_q == ST_STAGE4);
    m_tdata_o  = {si, out_y_q, out_x_q};
    s_hs       = s_tvalid_i && s_tready_o;
    m_hs       = m_tvalid_o && m_tready_i;
  end

  cmlp_coef #(.CNT_W(CNT_W)) u_coef (
    .stage_i(si), .layer_i(layer), .row_i(row_q), .col_i(col_q), .coef_o(coef)
  );

  cmlp_mac u_mac (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .fin_i(fin),
    .coef_i(coef), .opnd_i(opnd), .res_o(mac_res)
  );

  cmlp_act #(.NEG_SHIFT(NEG_SHIFT)) u_act (.x_i(mac_res), .y_o(act_res));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_LOAD;
      ld_q    <= '0;
      row_q   <= '0;
      col_q   <= '0;
      out_x_q <= '0;
      out_y_q <= '0;
      for (int i = 0; i < VEC_N; i++) begin
        in_vec_q[i]  <= '0;
        hid_vec_q[i] <= '0;
      end
    end else begin
      case (state_q)
        ST_IDLE: if (s_tvalid_i) begin
          state_q <= ST_STAGE1;
          phase_q <= PH_LOAD;
          ld_q    <= '0;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: begin
          case (phase_q)
            PH_LOAD: if (s_hs) begin
              in_vec_q[ld_q] <= s_tdata_i;
              if (ld_q == ld_last) begin
                phase_q <= PH_HID;
                row_q   <= '0;
                col_q   <= '0;
              end else begin
                ld_q <= ld_q + 1'b1;
              end
            end
            PH_HID, PH_OUT: begin
              if (fin) begin
                col_q <= '0;
                if (!layer)            hid_vec_q[row_q] <= act_res;
                else if (row_q == '0)  out_x_q <= mac_res;
                else                   out_y_q <= mac_res;
                if (row_q == cur_rows - 1'b1) begin
                  row_q   <= '0;
                  phase_q <= layer ? PH_EMIT : PH_OUT;
                end else begin
                  row_q <= row_q + 1'b1;
                end
              end else begin
                col_q <= col_q + 1'b1;
              end
            end
            default: if (m_hs) begin
              in_vec_q[0] <= out_x_q;
              in_vec_q[1] <= out_y_q;
              phase_q     <= PH_LOAD;
              ld_q        <= CNT_W'(2);
              case (state_q)
                ST_STAGE1: state_q <= ST_STAGE2;
                ST_STAGE2: state_q <= ST_STAGE3;
                ST_STAGE3: state_q <= ST_STAGE4;
                default:   state_q <= ST_DONE;
              endcase
            end
          endcase
        end
      endcase
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && !m_tready_i |=> m_tvalid_o && $stable(m_tdata_o)); // R8
  AST_LAST_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && m_tlast_o |-> m_tdata_o[TAG_W+2*DATA_W-1 -: TAG_W] == 2'd3); // R7
  AST_NO_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s_tready_o && m_tvalid_o)); // R10
  AST_NEXT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && m_tready_i && !m_tlast_o |=> s_tready_o); // R2
  AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && m_tready_i && m_tlast_o |=> !s_tready_o && !m_tvalid_o); // R9
endmodule

// File: tb/cmlp_engine_bench.sv
module cmlp_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tready;
  logic [33:0] m_tdata;
  logic        m_tvalid;
  logic        m_tready = 1'b0;
  logic        m_tlast;

  int errors = 0;
  int checks = 0;
  int lcg = 32'h1234_5678;

  always #2 clk = ~clk;

  cmlp_engine u_cmlp_engine (
    .clk_i(clk), .rst_ni(rst_n), .s_tdata_i(s_tdata), .s_tvalid_i(s_tvalid),
    .s_tready_o(s_tready), .m_tdata_o(m_tdata), .m_tvalid_o(m_tvalid),
    .m_tready_i(m_tready), .m_tlast_o(m_tlast)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model from R3, R4, R5, R6
  function automatic int wgt(int st, int ly, int r, int c);
    int h = st*97 + ly*53 + r*31 + c*17 + 7;
    if (h % 4 == 0) return 0;
    return ((h*37) % 256) - 128;
  endfunction

  function automatic int rsat(longint s);
    longint t = (s + 128) >>> 8;
    if (t > 32767) return 32767;
    if (t < -32768) return -32768;
    return int'(t);
  endfunction

  function automatic int leaky(int x);
    return (x < 0) ? (x >>> 7) : x;
  endfunction

  function automatic void ref_run(input int ext[10], output int rx[4], output int ry[4]);
    int nin[4] = '{6, 3, 4, 3};
    int nh[4]  = '{8, 8, 12, 6};
    int v[13];
    int hv[13];
    int k = 0;
    int px = 0, py = 0;
    for (int st = 0; st < 4; st++) begin
      if (st == 0) begin
        for (int i = 0; i < 6; i++) v[i] = ext[i];
        k = 6;
      end else begin
        v[0] = px; v[1] = py;
        for (int i = 2; i < nin[st]; i++) begin v[i] = ext[k]; k++; end
      end
      for (int r = 0; r < nh[st]; r++) begin
        longint s = 0;
        for (int c = 0; c < nin[st]; c++) s += longint'(wgt(st, 0, r, c)) * v[c];
        s += longint'(wgt(st, 0, r, nin[st])) * 256;
        hv[r] = leaky(rsat(s));
      end
      for (int r = 0; r < 2; r++) begin
        longint s = 0;
        for (int c = 0; c < nh[st]; c++) s += longint'(wgt(st, 1, r, c)) * hv[c];
        s += longint'(wgt(st, 1, r, nh[st])) * 256;
        if (r == 0) px = rsat(s); else py = rsat(s);
      end
      rx[st] = px; ry[st] = py;
    end
  endfunction

  task automatic send_beat(input int v);
    s_tvalid = 1'b1;
    s_tdata  = 16'(v);
    while (!s_tready) @(negedge clk);
    @(negedge clk);
    s_tvalid = 1'b0;
  endtask

  task automatic run_seq(input int ext[10], input int stall, input string name);
    int rx[4], ry[4];
    int k = 0;
    int ecnt[4] = '{6, 1, 2, 1};
    ref_run(ext, rx, ry);
    for (int st = 0; st < 4; st++) begin
      for (int i = 0; i < ecnt[st]; i++) begin send_beat(ext[k]); k++; end
      chk(!s_tready, {name, " R2 ready low while computing"}, s_tready, 0);
      while (!m_tvalid) @(negedge clk);
      if (stall > 0) begin
        logic [33:0] held = m_tdata;
        repeat (stall) @(negedge clk);
        chk(m_tvalid && m_tdata == held, {name, " R8 beat held under stall"}, m_tdata, held);
        chk(!s_tready, {name, " R10 no input while beat pending"}, s_tready, 0);
      end
      chk($signed(m_tdata[15:0]) == rx[st], {name, " R5,R6 x value"}, $signed(m_tdata[15:0]), rx[st]);
      chk($signed(m_tdata[31:16]) == ry[st], {name, " R3,R4 y value"}, $signed(m_tdata[31:16]), ry[st]);
      chk(m_tdata[33:32] == 2'(st), {name, " R7 stage tag"}, m_tdata[33:32], st);
      chk(m_tlast == (st == 3), {name, " R7 last flag"}, m_tlast, st == 3);
      m_tready = 1'b1;
      @(negedge clk);
      m_tready = 1'b0;
      if (st < 3) chk(s_tready, {name, " R2 next stage ready"}, s_tready, 1);
    end
    chk(!s_tready && !m_tvalid, {name, " R9 back to idle"}, {s_tready, m_tvalid}, 0);
  endtask

  function automatic int next_rand(int range);
    lcg = lcg * 1103515245 + 12345;
    return ((lcg >>> 8) & 32'h7fff_ffff) % range;
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!s_tready, "R1 ready after reset", s_tready, 0);
    chk(!m_tvalid, "R1 valid after reset", m_tvalid, 0);
  endtask

  task automatic t_zero();
    int e[10];
    foreach (e[i]) e[i] = 0;
    run_seq(e, 0, "zero");
  endtask

  task automatic t_random(input int n, input int stall);
    for (int j = 0; j < n; j++) begin
      int e[10];
      foreach (e[i]) e[i] = next_rand(4096) - 2048;
      run_seq(e, stall, "random");
    end
  endtask

  task automatic t_full_scale();
    int e[10];
    foreach (e[i]) e[i] = 32767;
    run_seq(e, 0, "satpos");
    foreach (e[i]) e[i] = -32768;
    run_seq(e, 0, "satneg");
    foreach (e[i]) e[i] = (i % 2) ? 32767 : -32768;
    run_seq(e, 2, "satmix");
  endtask

  task automatic t_back_to_back();
    for (int j = 0; j < 2; j++) begin
      int e[10];
      foreach (e[i]) e[i] = next_rand(65536) - 32768;
      run_seq(e, 0, "R9 b2b");
    end
  endtask

  initial begin
    t_reset();
    t_zero();
    t_random(4, 0);
    t_random(2, 3);
    t_full_scale();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule